// File: doc/BRIEF.md
# Test Clock Synchronizer with Return Clock

This block lets an external debug probe drive a JTAG test port on a processor that runs from a single core clock. The test clock (TCK) is never used as a clock. It is oversampled as an ordinary data input and passed through a short register chain. Each rising or falling TCK transition becomes a one-cycle enable in the core domain. The downstream TAP state machine and scan chains use these enables as their clock enables.

TMS and TDI go through synchronizers of the same depth as TCK. They are captured together with the rising-edge enable, so the TAP sees mode and data that line up with that enable. The TAP's serial output is registered onto TDO by the falling-edge enable. A return clock (RTCK) copies TCK after the full synchronizer delay. An adaptive probe can wait for RTCK before its next TCK edge, which keeps it in step with the core whether the core runs at tens of kHz or at several MHz. A probe that does not use RTCK works when TCK stays below one sixth of the core clock and TDO is read at the falling TCK edge.

Top module: `tck_sync_rtck`

## Requirements
- R1: `tapRiseEn` is high for exactly one core cycle. It is asserted by the third rising `clk` edge after a 0-to-1 change of `tckIn`.
- R2: `tapFallEn` is high for exactly one core cycle. It is asserted by the third rising `clk` edge after a 1-to-0 change of `tckIn`. The two enables are never high together.
- R3: `tapTms` and `tapTdi` take the synchronized `tmsIn`/`tdiIn` values at the same clock edge that raises `tapRiseEn`. At every other edge they hold, so changes of `tmsIn`/`tdiIn` between rising TCK edges have no effect.
- R4: `tdoOut` takes `tapTdoIn` at the edge that raises `tapFallEn` and holds at every other edge.
- R5: `rtckOut` is `tckIn` delayed by three core cycles. It reads 1 at the edge that raises `tapRiseEn` and 0 at the edge that raises `tapFallEn`.
- R6: While `rstN` is low, every output is 0. After reset, no enable is produced until `tckIn` really changes, even when `tckIn` is held at 1 through reset. `tckIn` must stay still for three cycles after release.
- R7: Every TCK level that lasts at least two core cycles yields exactly one enable of the matching kind, whatever the TCK-to-core ratio. No enable appears without a TCK change.
- R8: When each TCK level lasts three or more core cycles, `tdoOut` at every falling TCK transition already holds the bit presented at the previous falling transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tckIn | input | 1 | External test clock, sampled as data |
| tmsIn | input | 1 | External test mode select |
| tdiIn | input | 1 | External test data in |
| tapTdoIn | input | 1 | Serial output bit from the TAP logic |
| tapRiseEn | output | 1 | One-cycle enable for a rising TCK transition |
| tapFallEn | output | 1 | One-cycle enable for a falling TCK transition |
| tapTms | output | 1 | TMS captured with the rising enable |
| tapTdi | output | 1 | TDI captured with the rising enable |
| tdoOut | output | 1 | Test data out to the probe |
| rtckOut | output | 1 | Return clock, TCK after the synchronizer delay |

## Verification
TCK is driven with level widths of 2, 3, 4, 6 and 12 core cycles. This separates exact three-cycle latency from latency that depends on the ratio, and shows whether fast TCK loses or doubles an enable. On every falling transition TMS and TDI are flipped to their opposite values, which exposes a capture that is not gated by the rising enable. Alternating TDO bits show whether the output moves only on the falling enable and is settled when the probe reads it. A reset with TCK held high tells a properly armed edge detector apart from one that reports the reset value as an edge.

// File: rtl/tck_sync_pkg.sv
package tck_sync_pkg;

  // Edge strobes decoded by the control path, consumed by the datapath
  typedef struct packed {
    logic riseDet;
    logic fallDet;
  } tckStrobes_t;

endpackage

// File: rtl/tck_sync_ctrl.sv
module tck_sync_ctrl
  import tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tckIn,
  output tckStrobes_t strobes,
  output logic        rtckOut
);

  // Synchronizer stages plus one history stage for edge detection
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] tckSr;
  logic [CHAIN-1:0] fillSr;
  logic             newer;
  logic             older;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tckSr  <= '0;
      fillSr <= '0;
    end else begin
      tckSr  <= {tckSr[CHAIN-2:0], tckIn};
      fillSr <= {fillSr[CHAIN-2:0], 1'b1};
    end
  end

  assign newer = tckSr[CHAIN-2];
  assign older = tckSr[CHAIN-1];
  // Edges count only once the chain holds real samples, not reset zeros
  assign armed = fillSr[CHAIN-1];

  always_comb begin
    strobes.riseDet = armed & newer & ~older;
    strobes.fallDet = armed & ~newer & older;
  end

  assign rtckOut = older;

endmodule

// File: rtl/tck_sync_dp.sv
module tck_sync_dp
  import tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  tckStrobes_t strobes,
  input  logic        tmsIn,
  input  logic        tdiIn,
  input  logic        tapTdoIn,
  output logic        riseEn,
  output logic        fallEn,
  output logic        tapTms,
  output logic        tapTdi,
  output logic        tdoOut
);

  localparam int LAST = SYNC_STAGES - 1;

  // Same depth as the clock chain so data lines up with the edge
  logic [LAST:0] tmsSr;
  logic [LAST:0] tdiSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmsSr  <= '0;
      tdiSr  <= '0;
      riseEn <= 1'b0;
      fallEn <= 1'b0;
      tapTms <= 1'b0;
      tapTdi <= 1'b0;
      tdoOut <= 1'b0;
    end else begin
      tmsSr  <= {tmsSr[LAST-1:0], tmsIn};
      tdiSr  <= {tdiSr[LAST-1:0], tdiIn};
      riseEn <= strobes.riseDet;
      fallEn <= strobes.fallDet;
      if (strobes.riseDet) begin
        tapTms <= tmsSr[LAST];
        tapTdi <= tdiSr[LAST];
      end
      if (strobes.fallDet) begin
        tdoOut <= tapTdoIn;
      end
    end
  end

endmodule

// File: rtl/tck_sync_rtck.sv
module tck_sync_rtck
  import tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tckIn,
  input  logic tmsIn,
  input  logic tdiIn,
  input  logic tapTdoIn,
  output logic tapRiseEn,
  output logic tapFallEn,
  output logic tapTms,
  output logic tapTdi,
  output logic tdoOut,
  output logic rtckOut
);

  tckStrobes_t strobes;

  tck_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tckIn   (tckIn),
    .strobes (strobes),
    .rtckOut (rtckOut)
  );

  tck_sync_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tmsIn    (tmsIn),
    .tdiIn    (tdiIn),
    .tapTdoIn (tapTdoIn),
    .riseEn   (tapRiseEn),
    .fallEn   (tapFallEn),
    .tapTms   (tapTms),
    .tapTdi   (tapTdi),
    .tdoOut   (tdoOut)
  );

endmodule

// File: rtl/tck_sync_rtck_chk.sv
module tck_sync_rtck_chk (
  input logic clk,
  input logic rstN,
  input logic riseEn,
  input logic fallEn,
  input logic tapTms,
  input logic tapTdi,
  input logic tdoOut,
  input logic rtckOut
);

  // R1 R5
  rise_rtck_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEn |-> (rtckOut && !$past(rtckOut)));

  // R2 R5
  fall_rtck_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEn |-> (!rtckOut && $past(rtckOut)));

  // R2
  enable_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEn && fallEn));

  // R3
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !riseEn |-> ($stable(tapTms) && $stable(tapTdi)));

  // R4
  tdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fallEn |-> $stable(tdoOut));

endmodule

bind tck_sync_rtck tck_sync_rtck_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .riseEn  (tapRiseEn),
  .fallEn  (tapFallEn),
  .tapTms  (tapTms),
  .tapTdi  (tapTdi),
  .tdoOut  (tdoOut),
  .rtckOut (rtckOut)
);

// File: tb/tck_sync_rtck_test.sv
module tck_sync_rtck_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tckIn = 1'b1;
  logic tmsIn = 1'b0;
  logic tdiIn = 1'b0;
  logic tapTdoIn = 1'b0;
  logic tapRiseEn, tapFallEn, tapTms, tapTdi, tdoOut, rtckOut;

  always #4 clk = ~clk;

  tck_sync_rtck uut (
    .clk(clk), .rstN(rstN), .tckIn(tckIn), .tmsIn(tmsIn), .tdiIn(tdiIn),
    .tapTdoIn(tapTdoIn), .tapRiseEn(tapRiseEn), .tapFallEn(tapFallEn),
    .tapTms(tapTms), .tapTdi(tapTdi), .tdoOut(tdoOut), .rtckOut(rtckOut)
  );

  typedef struct {
    int cyc;
    bit isRise;
    bit tms;
    bit tdi;
    bit tdo;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  lastTdi = 1'b0;
  bit  lastTms = 1'b0;
  bit  prevTdo = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when an enable is due
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.isRise) begin
          chk(tapRiseEn && !tapFallEn, "R1 rise enable latency", {tapRiseEn, tapFallEn}, 2);
          chk(rtckOut == 1'b1, "R5 rtck high with rise enable", rtckOut, 1);
          chk(tapTms == it.tms && tapTdi == it.tdi, "R3 TMS/TDI capture",
              {tapTms, tapTdi}, {it.tms, it.tdi});
          lastTms = it.tms;
          lastTdi = it.tdi;
        end else begin
          chk(tapFallEn && !tapRiseEn, "R2 fall enable latency", {tapRiseEn, tapFallEn}, 1);
          chk(rtckOut == 1'b0, "R5 rtck low with fall enable", rtckOut, 0);
          chk(tdoOut == it.tdo, "R4 TDO update", tdoOut, it.tdo);
          chk(tapTms == lastTms && tapTdi == lastTdi, "R3 hold between rises",
              {tapTms, tapTdi}, {lastTms, lastTdi});
        end
      end else if (tapRiseEn || tapFallEn) begin
        chk(1'b0, "R7 spurious enable", {tapRiseEn, tapFallEn}, 0);
      end
    end
  end

  task automatic fallEdge(input int halfCyc, input bit tdoBit, input bit junkTms, input bit junkTdi);
    @(negedge clk);
    if (halfCyc >= 3)
      chk(tdoOut == prevTdo, "R8 TDO settled at falling TCK", tdoOut, prevTdo);
    tckIn = 1'b0;
    tapTdoIn = tdoBit;
    tmsIn = junkTms;
    tdiIn = junkTdi;
    expQ.push_back('{cyc + 3, 1'b0, 1'b0, 1'b0, tdoBit});
    prevTdo = tdoBit;
  endtask

  // One TCK period: data set up while low, rise, hold, fall with junk data
  task automatic tckBit(input int halfCyc, input bit tms, input bit tdi, input bit tdoBit);
    @(negedge clk);
    tmsIn = tms;
    tdiIn = tdi;
    @(negedge clk);
    tckIn = 1'b1;
    expQ.push_back('{cyc + 3, 1'b1, tms, tdi, 1'b0});
    repeat (halfCyc - 1) @(negedge clk);
    fallEdge(halfCyc, tdoBit, ~tms, ~tdi);
    repeat (halfCyc - 2) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int halves[5] = '{4, 3, 6, 12, 2};
    // R6: reset with TCK held high
    repeat (3) @(negedge clk);
    chk({tapRiseEn, tapFallEn, tapTms, tapTdi, tdoOut, rtckOut} == 6'd0,
        "R6 outputs zero in reset", {tapRiseEn, tapFallEn, tapTms, tapTdi, tdoOut, rtckOut}, 0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    chk(rtckOut == 1'b1, "R6 rtck follows held TCK", rtckOut, 1);
    chk(!tapRiseEn && !tapFallEn && tdoOut == 1'b0, "R6 no enable without TCK change",
        {tapRiseEn, tapFallEn}, 0);
    chk(expQ.size() == 0, "R6 no pending events", expQ.size(), 0);
    fallEdge(0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    for (int h = 0; h < 5; h++) begin
      for (int b = 0; b < 8; b++) begin
        tckBit(halves[h], b[0] ^ h[0], b[1], b[0] ^ b[2]);
      end
    end
    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R7 every TCK edge produced an enable", expQ.size(), 0);
    // R7: long idle, no enables (monitor flags any)
    repeat (30) @(negedge clk);
    chk(tdoOut == prevTdo, "R4 TDO holds while idle", tdoOut, prevTdo);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule